// File: doc/BRIEF.md
# Byte ALU with Registered Status Flags

This block is the arithmetic and logic unit of a small 8-bit controller core. One operation is issued per cycle along with the working-register value, a file-register operand, an 8-bit literal, a bit index, a destination select and the current carry. The block computes the result and works out which destination it goes to. It also produces new carry, digit-carry and zero flags, each with its own write enable. All of these outputs are registered, so they appear one clock after the request.

Each operation class owns a fixed set of flags, and the block raises the write enable only for that set. A status register downstream writes a flag only when its enable is high, so it keeps every flag the operation does not own. Subtraction adds the complement of the working register, the file operand and one. Its carry therefore means that no borrow occurred. Operand fetch, banking and indirect addressing are handled elsewhere.

Top module: `alu8_status_alu`

## Requirements
- R1: During reset, and one cycle after any cycle with `req_valid_i` low, `out_valid_o`, `result_o`, `to_file_o`, every flag and every flag enable read 0.
- R2: Op 5'h00 (add) yields W+F modulo 256, with carry equal to the carry out of bit 7 and digit carry equal to the carry out of bit 3. All three flag enables are high.
- R3: Op 5'h01 (subtract) yields F-W modulo 256. Carry is 1 when F >= W (no borrow), and digit carry is 1 when F[3:0] >= W[3:0]. All three flag enables are high.
- R4: The ops AND, OR and XOR with F (5'h02, 5'h03, 5'h04) and with the literal (5'h05, 5'h06, 5'h07) combine W with the second operand bitwise. Only the zero enable is high.
- R5: The ops complement F (5'h08), F+1 (5'h09), F-1 (5'h0A), copy F (5'h12), clear to file (5'h10) and clear to working (5'h11) update only the zero flag.
- R6: Op 5'h0B rotates {C,F} left by one through carry, giving result {F[6:0],C} and new carry F[7]. Op 5'h0C rotates right, giving result {C,F[7:1]} and new carry F[0]. Only the carry enable is high.
- R7: Op 5'h0D exchanges F[3:0] and F[7:4], and all flag enables are low.
- R8: Ops 5'h0E (clear) and 5'h0F (set) change the single bit of F selected by the 3-bit index. They always write the file register, and all flag enables are low.
- R9: `to_file_o` is 1 when the result goes to the file register and 0 when it goes to the working register. The register forms (5'h00 to 5'h04, 5'h08 to 5'h0D, 5'h12) follow `dest_file_i`. The literal forms and clear-to-working always give 0. Clear-to-file and op 5'h14 (store W, result = W) always give 1.
- R10: Op 5'h13 (load literal) returns the literal to the working register, and all flag enables are low.
- R11: When a flag's enable is low, that flag output reads 0. When the zero enable is high, `zero_o` is 1 exactly when `result_o` is 0.
- R12: Results appear on the outputs one cycle after the request. Back-to-back requests give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Operation request this cycle |
| op_i | input | 5 | Operation code |
| wreg_i | input | 8 | Working register value |
| freg_i | input | 8 | File register operand |
| lit_i | input | 8 | Literal operand |
| bit_sel_i | input | 3 | Bit index for set/clear |
| dest_file_i | input | 1 | Register-form destination: 1 file, 0 working |
| carry_i | input | 1 | Current carry flag |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 8 | Operation result |
| to_file_o | output | 1 | Result destination: 1 file, 0 working |
| carry_o | output | 1 | New carry |
| dcarry_o | output | 1 | New digit carry |
| zero_o | output | 1 | New zero flag |
| carry_we_o | output | 1 | Carry write enable |
| dcarry_we_o | output | 1 | Digit-carry write enable |
| zero_we_o | output | 1 | Zero write enable |

## Verification
Some properties are checked on every cycle: the zero flag agrees with the result, disabled flags read low, idle requests produce quiet outputs, and literal forms never target the file register. Further per-cycle checks cover the flag sets of swap and rotate, the rotate carry source, and the no-borrow meaning of the subtract carry. Exact result values, digit carry on nibble boundaries, bit-index decoding and the destination routing of each op class are shown only by the bench's scenarios. These use directed boundary vectors plus a long pseudo-random stream compared against an independent model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD     = 5'h00,
        OP_SUB     = 5'h01,
        OP_AND_R   = 5'h02,
        OP_IOR_R   = 5'h03,
        OP_XOR_R   = 5'h04,
        OP_AND_K   = 5'h05,
        OP_IOR_K   = 5'h06,
        OP_XOR_K   = 5'h07,
        OP_NOT     = 5'h08,
        OP_INC     = 5'h09,
        OP_DEC     = 5'h0A,
        OP_ROL     = 5'h0B,
        OP_ROR     = 5'h0C,
        OP_SWAP    = 5'h0D,
        OP_BITCLR  = 5'h0E,
        OP_BITSET  = 5'h0F,
        OP_ZERO_F  = 5'h10,
        OP_ZERO_W  = 5'h11,
        OP_COPY_F  = 5'h12,
        OP_LOAD_K  = 5'h13,
        OP_STORE_W = 5'h14
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flag_set_t;

    typedef enum logic [1:0] {
        DST_SEL  = 2'd0,
        DST_WREG = 2'd1,
        DST_FILE = 2'd2
    } dst_rule_e;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  alu_op_e   op_i,
    output flag_set_t flag_we_o,
    output dst_rule_e dst_rule_o,
    output logic      use_adder_o
);
    always_comb begin
        flag_we_o   = '0;
        dst_rule_o  = DST_SEL;
        use_adder_o = 1'b0;
        unique case (op_i)
            OP_ADD, OP_SUB: begin
                flag_we_o   = '{c: 1'b1, dc: 1'b1, z: 1'b1};
                use_adder_o = 1'b1;
            end
            OP_INC, OP_DEC: begin
                flag_we_o.z = 1'b1;
                use_adder_o = 1'b1;
            end
            OP_AND_R, OP_IOR_R, OP_XOR_R, OP_NOT, OP_COPY_F:
                flag_we_o.z = 1'b1;
            OP_AND_K, OP_IOR_K, OP_XOR_K: begin
                flag_we_o.z = 1'b1;
                dst_rule_o  = DST_WREG;
            end
            OP_ZERO_W: begin
                flag_we_o.z = 1'b1;
                dst_rule_o  = DST_WREG;
            end
            OP_ZERO_F: begin
                flag_we_o.z = 1'b1;
                dst_rule_o  = DST_FILE;
            end
            OP_ROL, OP_ROR:
                flag_we_o.c = 1'b1;
            OP_SWAP:
                dst_rule_o  = DST_SEL;
            OP_BITCLR, OP_BITSET, OP_STORE_W:
                dst_rule_o  = DST_FILE;
            OP_LOAD_K:
                dst_rule_o  = DST_WREG;
            default:
                dst_rule_o  = DST_WREG;
        endcase
    end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             hcout_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0] full_sum;
    logic [HALF:0]  low_sum;

    always_comb begin
        full_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        low_sum  = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
        sum_o    = full_sum[WIDTH-1:0];
        cout_o   = full_sum[WIDTH];
        hcout_o  = low_sum[HALF];
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] w_i,
    input  logic [WIDTH-1:0] f_i,
    input  logic [WIDTH-1:0] k_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] bit_mask;

    for (genvar g = 0; g < WIDTH; g++) begin : g_mask
        assign bit_mask[g] = (idx_i == IDX_W'(g));
    end

    always_comb begin
        res_o  = '0;
        cout_o = 1'b0;
        unique case (op_i)
            OP_AND_R:   res_o = w_i & f_i;
            OP_IOR_R:   res_o = w_i | f_i;
            OP_XOR_R:   res_o = w_i ^ f_i;
            OP_AND_K:   res_o = w_i & k_i;
            OP_IOR_K:   res_o = w_i | k_i;
            OP_XOR_K:   res_o = w_i ^ k_i;
            OP_NOT:     res_o = ~f_i;
            OP_ROL:     {cout_o, res_o} = {f_i, cin_i};
            OP_ROR:     {res_o, cout_o} = {cin_i, f_i};
            OP_SWAP:    res_o = {f_i[HALF-1:0], f_i[WIDTH-1:HALF]};
            OP_BITCLR:  res_o = f_i & ~bit_mask;
            OP_BITSET:  res_o = f_i | bit_mask;
            OP_COPY_F:  res_o = f_i;
            OP_LOAD_K:  res_o = k_i;
            OP_STORE_W: res_o = w_i;
            default:    res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_status_alu.sv
module alu8_status_alu
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = $clog2(WIDTH),
    parameter int OP_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] wreg_i,
    input  logic [WIDTH-1:0] freg_i,
    input  logic [WIDTH-1:0] lit_i,
    input  logic [IDX_W-1:0] bit_sel_i,
    input  logic             dest_file_i,
    input  logic             carry_i,
    output logic             out_valid_o,
    output logic [WIDTH-1:0] result_o,
    output logic             to_file_o,
    output logic             carry_o,
    output logic             dcarry_o,
    output logic             zero_o,
    output logic             carry_we_o,
    output logic             dcarry_we_o,
    output logic             zero_we_o
);
    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] result;
        logic             to_file;
        flag_set_t        flags;
        flag_set_t        we;
    } out_state_t;

    alu_op_e          op;
    flag_set_t        we_dec;
    dst_rule_e        dst_rule;
    logic             use_adder;
    logic [WIDTH-1:0] add_a, add_b, add_sum, bit_res;
    logic             add_cin, add_cout, add_hcout, bit_cout;
    out_state_t       state_d, state_q;

    assign op = alu_op_e'(op_i);

    alu8_decode u_decode (
        .op_i        (op),
        .flag_we_o   (we_dec),
        .dst_rule_o  (dst_rule),
        .use_adder_o (use_adder)
    );

    always_comb begin
        add_a   = wreg_i;
        add_b   = freg_i;
        add_cin = 1'b0;
        unique case (op)
            OP_SUB: begin add_a = ~wreg_i;     add_cin = 1'b1; end
            OP_INC: begin add_a = '0;          add_cin = 1'b1; end
            OP_DEC: begin add_a = '1;          add_cin = 1'b0; end
            default: ;
        endcase
    end

    alu8_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i     (add_a),
        .b_i     (add_b),
        .cin_i   (add_cin),
        .sum_o   (add_sum),
        .cout_o  (add_cout),
        .hcout_o (add_hcout)
    );

    alu8_bitops #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_bitops (
        .op_i   (op),
        .w_i    (wreg_i),
        .f_i    (freg_i),
        .k_i    (lit_i),
        .idx_i  (bit_sel_i),
        .cin_i  (carry_i),
        .res_o  (bit_res),
        .cout_o (bit_cout)
    );

    always_comb begin
        state_d = '0;
        if (req_valid_i) begin
            state_d.valid  = 1'b1;
            state_d.result = use_adder ? add_sum : bit_res;
            state_d.we     = we_dec;
            unique case (dst_rule)
                DST_WREG: state_d.to_file = 1'b0;
                DST_FILE: state_d.to_file = 1'b1;
                default:  state_d.to_file = dest_file_i;
            endcase
            state_d.flags.c  = we_dec.c  & (use_adder ? add_cout : bit_cout);
            state_d.flags.dc = we_dec.dc & add_hcout;
            state_d.flags.z  = we_dec.z  & (state_d.result == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid_o = state_q.valid;
    assign result_o    = state_q.result;
    assign to_file_o   = state_q.to_file;
    assign carry_o     = state_q.flags.c;
    assign dcarry_o    = state_q.flags.dc;
    assign zero_o      = state_q.flags.z;
    assign carry_we_o  = state_q.we.c;
    assign dcarry_we_o = state_q.we.dc;
    assign zero_we_o   = state_q.we.z;
endmodule

// File: rtl/alu8_status_alu_chk.sv
module alu8_status_alu_chk
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = $clog2(WIDTH),
    parameter int OP_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic [OP_W-1:0]  op_i,
    input logic [WIDTH-1:0] wreg_i,
    input logic [WIDTH-1:0] freg_i,
    input logic             out_valid_o,
    input logic [WIDTH-1:0] result_o,
    input logic             to_file_o,
    input logic             carry_o,
    input logic             dcarry_o,
    input logic             zero_o,
    input logic             carry_we_o,
    input logic             dcarry_we_o,
    input logic             zero_we_o
);
    logic is_lit, is_swap, is_rol, is_sub;
    assign is_lit  = (op_i == OP_AND_K) || (op_i == OP_IOR_K) ||
                     (op_i == OP_XOR_K) || (op_i == OP_LOAD_K);
    assign is_swap = (op_i == OP_SWAP);
    assign is_rol  = (op_i == OP_ROL);
    assign is_sub  = (op_i == OP_SUB);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !out_valid_o && !carry_we_o && !dcarry_we_o && !zero_we_o);

    p_zero_matches_r11: assert property (@(posedge clk) disable iff (!rst_n)
        zero_we_o |-> (zero_o == (result_o == '0)));

    p_off_flags_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_we_o || !carry_o) && (dcarry_we_o || !dcarry_o) && (zero_we_o || !zero_o));

    p_swap_no_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && is_swap |=> out_valid_o && !carry_we_o && !dcarry_we_o && !zero_we_o);

    p_rol_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && is_rol |=> carry_we_o && !dcarry_we_o && !zero_we_o &&
                                  (carry_o == $past(freg_i[WIDTH-1])));

    p_literal_to_w_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && is_lit |=> out_valid_o && !to_file_o);

    p_sub_no_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && is_sub |=> carry_o == ($past(freg_i) >= $past(wreg_i)));
endmodule

bind alu8_status_alu alu8_status_alu_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W), .OP_W(OP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .op_i        (op_i),
    .wreg_i      (wreg_i),
    .freg_i      (freg_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o),
    .to_file_o   (to_file_o),
    .carry_o     (carry_o),
    .dcarry_o    (dcarry_o),
    .zero_o      (zero_o),
    .carry_we_o  (carry_we_o),
    .dcarry_we_o (dcarry_we_o),
    .zero_we_o   (zero_we_o)
);

// File: tb/alu8_status_alu_bench.sv
module alu8_status_alu_bench;
    import alu8_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] wreg_i = '0, freg_i = '0, lit_i = '0;
    logic [2:0] bit_sel_i = '0;
    logic       dest_file_i = 1'b0, carry_i = 1'b0;
    logic       out_valid_o, to_file_o, carry_o, dcarry_o, zero_o;
    logic       carry_we_o, dcarry_we_o, zero_we_o;
    logic [7:0] result_o;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    alu8_status_alu u_alu8_status_alu (.*);

    typedef struct {
        logic       v;
        logic [7:0] res;
        logic       tf, c, dc, z, cwe, dcwe, zwe;
        string      tag;
        int         cyc;
    } exp_t;

    exp_t sb[$];

    function automatic exp_t model(logic v, alu_op_e op, logic [7:0] w, f, k,
                                   logic [2:0] b, logic d, logic ci);
        exp_t e;
        logic [8:0] t9;
        e = '{v: 1'b0, res: 8'h00, tf: 1'b0, c: 1'b0, dc: 1'b0, z: 1'b0,
              cwe: 1'b0, dcwe: 1'b0, zwe: 1'b0, tag: "R1", cyc: 0};
        if (!v) return e;
        e.v = 1'b1;
        e.tf = d;
        case (op)
            OP_ADD: begin
                t9 = {1'b0, w} + {1'b0, f};
                e.res = t9[7:0]; e.c = t9[8];
                e.dc = ({1'b0, w[3:0]} + {1'b0, f[3:0]}) > 5'd15;
                e.cwe = 1; e.dcwe = 1; e.zwe = 1; e.tag = "R2";
            end
            OP_SUB: begin
                e.res = f - w; e.c = (f >= w); e.dc = (f[3:0] >= w[3:0]);
                e.cwe = 1; e.dcwe = 1; e.zwe = 1; e.tag = "R3";
            end
            OP_AND_R: begin e.res = w & f; e.zwe = 1; e.tag = "R4"; end
            OP_IOR_R: begin e.res = w | f; e.zwe = 1; e.tag = "R4"; end
            OP_XOR_R: begin e.res = w ^ f; e.zwe = 1; e.tag = "R4"; end
            OP_AND_K: begin e.res = w & k; e.zwe = 1; e.tf = 0; e.tag = "R4"; end
            OP_IOR_K: begin e.res = w | k; e.zwe = 1; e.tf = 0; e.tag = "R4"; end
            OP_XOR_K: begin e.res = w ^ k; e.zwe = 1; e.tf = 0; e.tag = "R4"; end
            OP_NOT:    begin e.res = ~f;     e.zwe = 1; e.tag = "R5"; end
            OP_INC:    begin e.res = f + 1;  e.zwe = 1; e.tag = "R5"; end
            OP_DEC:    begin e.res = f - 1;  e.zwe = 1; e.tag = "R5"; end
            OP_COPY_F: begin e.res = f;      e.zwe = 1; e.tag = "R5"; end
            OP_ZERO_F: begin e.res = 0; e.tf = 1; e.zwe = 1; e.tag = "R5"; end
            OP_ZERO_W: begin e.res = 0; e.tf = 0; e.zwe = 1; e.tag = "R5"; end
            OP_ROL: begin e.res = {f[6:0], ci}; e.c = f[7]; e.cwe = 1; e.tag = "R6"; end
            OP_ROR: begin e.res = {ci, f[7:1]}; e.c = f[0]; e.cwe = 1; e.tag = "R6"; end
            OP_SWAP:   begin e.res = {f[3:0], f[7:4]}; e.tag = "R7"; end
            OP_BITCLR: begin e.res = f; e.res[b] = 1'b0; e.tf = 1; e.tag = "R8"; end
            OP_BITSET: begin e.res = f; e.res[b] = 1'b1; e.tf = 1; e.tag = "R8"; end
            OP_LOAD_K: begin e.res = k; e.tf = 0; e.tag = "R10"; end
            OP_STORE_W: begin e.res = w; e.tf = 1; e.tag = "R9"; end
            default: begin e.res = 0; e.tf = 0; e.tag = "R1"; end
        endcase
        if (e.zwe) e.z = (e.res == 8'h00);
        return e;
    endfunction

    task automatic send(logic v, alu_op_e op, logic [7:0] w, f, k, logic [2:0] b,
                        logic d, logic ci, string tag);
        exp_t e;
        @(negedge clk);
        req_valid_i = v; op_i = op; wreg_i = w; freg_i = f; lit_i = k;
        bit_sel_i = b; dest_file_i = d; carry_i = ci;
        e = model(v, op, w, f, k, b, d, ci);
        if (tag != "") e.tag = tag;
        e.cyc = cyc;
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb.size() > 0 && sb[0].cyc < cyc) begin
                e = sb.pop_front();
                checks++;
                if (out_valid_o !== e.v || result_o !== e.res || to_file_o !== e.tf ||
                    carry_o !== e.c || dcarry_o !== e.dc || zero_o !== e.z ||
                    carry_we_o !== e.cwe || dcarry_we_o !== e.dcwe || zero_we_o !== e.zwe) begin
                    errors++;
                    $display("FAIL %s: got v=%b res=%h tf=%b c/dc/z=%b%b%b we=%b%b%b exp v=%b res=%h tf=%b c/dc/z=%b%b%b we=%b%b%b",
                        e.tag, out_valid_o, result_o, to_file_o, carry_o, dcarry_o, zero_o,
                        carry_we_o, dcarry_we_o, zero_we_o, e.v, e.res, e.tf, e.c, e.dc, e.z,
                        e.cwe, e.dcwe, e.zwe);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        logic [31:0] rng;
        rng = 32'h1234_5678;
        repeat (3) @(negedge clk);
        checks++;  // R1 reset state
        if (out_valid_o !== 1'b0 || result_o !== 8'h00 || carry_we_o !== 1'b0 ||
            dcarry_we_o !== 1'b0 || zero_we_o !== 1'b0 || zero_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: got v=%b res=%h in reset, exp 0 0", out_valid_o, result_o);
        end
        rst_n = 1'b1;

        // R2 add boundaries
        send(1, OP_ADD, 8'h0F, 8'h01, 0, 0, 1, 0, "R2");
        send(1, OP_ADD, 8'hF0, 8'h10, 0, 0, 0, 0, "R2");
        send(1, OP_ADD, 8'h88, 8'h88, 0, 0, 1, 1, "R2");
        // R3 subtract: equal, borrow, nibble borrow
        send(1, OP_SUB, 8'h05, 8'h05, 0, 0, 1, 0, "R3");
        send(1, OP_SUB, 8'h06, 8'h05, 0, 0, 0, 1, "R3");
        send(1, OP_SUB, 8'h01, 8'h10, 0, 0, 1, 0, "R3");
        // R4 logic, R10 load literal
        send(1, OP_AND_K, 8'hF0, 8'h00, 8'h0F, 0, 1, 0, "R4");
        send(1, OP_XOR_R, 8'hA5, 8'h5A, 0, 0, 1, 1, "R4");
        send(1, OP_LOAD_K, 8'h00, 8'h00, 8'h00, 0, 1, 1, "R10");
        // R5 inc/dec wrap
        send(1, OP_INC, 0, 8'hFF, 0, 0, 0, 0, "R5");
        send(1, OP_DEC, 0, 8'h00, 0, 0, 1, 0, "R5");
        send(1, OP_ZERO_W, 8'h33, 8'h44, 0, 0, 1, 1, "R5");
        // R6 rotates through carry
        send(1, OP_ROL, 0, 8'h80, 0, 0, 1, 1, "R6");
        send(1, OP_ROR, 0, 8'h01, 0, 0, 0, 0, "R6");
        send(1, OP_ROR, 0, 8'h00, 0, 0, 1, 1, "R6");
        // R7 swap, R8 bit ops at both ends
        send(1, OP_SWAP, 0, 8'h3C, 0, 0, 0, 1, "R7");
        send(1, OP_BITSET, 0, 8'h00, 0, 3'd7, 0, 0, "R8");
        send(1, OP_BITCLR, 0, 8'hFF, 0, 3'd0, 0, 0, "R8");
        // R9 destination routing
        send(1, OP_COPY_F, 0, 8'h12, 0, 0, 0, 0, "R9");
        send(1, OP_COPY_F, 0, 8'h12, 0, 0, 1, 0, "R9");
        send(1, OP_STORE_W, 8'h77, 0, 0, 0, 0, 0, "R9");
        send(1, OP_ZERO_F, 0, 8'h99, 0, 0, 0, 0, "R9");
        // R11 disabled flags read 0 with nonzero carry input
        send(1, OP_SWAP, 8'hFF, 8'hFF, 0, 0, 1, 1, "R11");
        // R1 idle gap then R12 back to back
        send(0, OP_ADD, 8'hFF, 8'hFF, 0, 0, 1, 1, "R1");
        send(0, OP_ADD, 8'h01, 8'h01, 0, 0, 1, 1, "R1");
        send(1, OP_INC, 0, 8'h41, 0, 0, 1, 0, "R12");
        send(1, OP_INC, 0, 8'h42, 0, 0, 1, 0, "R12");

        for (int i = 0; i < 400; i++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            send(rng[31:29] != 3'd0, alu_op_e'(rng[28:24] % 21), rng[7:0], rng[15:8],
                 rng[23:16], rng[2:0], rng[9], rng[17], "");
        end
        send(0, OP_ADD, 0, 0, 0, 0, 0, 0, "R1");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule